// File: doc/BRIEF.md
# Debug External Event Input Conditioner

This block brings an asynchronous external event pin into a debug unit that runs on the core bus clock. The pin is idle high. It goes through a synchronizer, and a falling edge of the synchronized level is an event. A 2-bit mode input decides what the pin does. It can be off. It can send a one-cycle event to the state sequencer. It can send a one-cycle entry request to the trace buffer. Or it can act as a level gate on trace buffer writes.

Event pulses are qualified by an arm input. The arm check uses the delayed, synchronized event. So an edge that reaches the pin shortly before the unit is armed still counts as an armed event. A stop-mode input freezes the synchronizer and blocks all events. The sequencer, the trace buffer and the register access logic sit outside the block. The mode field comes straight in on a port.

Top module: `dbg_eev_cond`

## Requirements
- R1: A pin level that is present at clock edge k becomes the internal synchronized level after edge k+1. A falling edge on the pin that is first sampled at edge k therefore produces its pulse in the cycle between edges k+1 and k+2, which is two cycles of latency.
- R2: Only a high-to-low transition of the synchronized level is an event. A rising edge, or a level that does not change, produces no pulse.
- R3: The mode encoding is as follows: 2'b00 off, 2'b01 sequencer event, 2'b10 trace entry event, 2'b11 trace gating. `seq_evt_o` is set only in mode 2'b01, and `trc_req_o` is set only in mode 2'b10. Mode 2'b00 produces no pulses.
- R4: `trc_gate_o` is 1 for allow and 0 for suppress. In mode 2'b11 it is 1 when the synchronized level is low and 0 when it is high. In every other mode it is 1.
- R5: A pulse is produced only while `armed_i` is 1 in the cycle in which the synchronized falling edge appears. Arming after the pin edge but before the synchronized edge still gives a pulse.
- R6: Falling edges at half the clock rate, each separated by a single high cycle, each give a separate pulse.
- R7: While `stop_i` is 1, the synchronizer stages hold their values, no pulses are produced, and `trc_gate_o` holds while the mode is unchanged.
- R8: Reset loads every synchronizer stage and the edge history with 1 (idle). This means no false edge after release, and `trc_gate_o` reads 0 in mode 2'b11 until a low level has been sampled.
- R9: After stop is released, the edge history matches the frozen synchronized level. A pin that stays at its pre-stop level gives no pulse.
- R10: Every event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eev_pin_i | input | 1 | Asynchronous external event pin, idle high |
| stop_i | input | 1 | Stop mode: freezes the synchronizer and blocks events |
| armed_i | input | 1 | Debug unit armed; qualifies the event pulses |
| mode_i | input | 2 | Pin function select (see R3) |
| seq_evt_o | output | 1 | One-cycle state sequencer event |
| trc_req_o | output | 1 | One-cycle trace buffer entry request |
| trc_gate_o | output | 1 | Trace write gate, 1 = allow |

## Verification
The bench builds the block with its default of two synchronizer stages. At this depth the two-cycle latency, the late-arm case and half-rate toggling can be checked cycle for cycle against a queue-based model. Directed phases cover reset, each mode, rising edges, arming, stop entry and stop exit. A long random phase then mixes pin toggles, mode changes, arming and stop cycles.

// File: rtl/dbg_eev_pkg.sv
package dbg_eev_pkg;
  typedef enum logic [1:0] {
    EEV_OFF   = 2'b00,
    EEV_SEQ   = 2'b01,
    EEV_TRACE = 2'b10,
    EEV_GATE  = 2'b11
  } eev_mode_e;
endpackage

// File: rtl/dbg_eev_sync.sv
module dbg_eev_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_head
      assign src = d_i;
    end else begin : g_tail
      assign src = stg_q[g-1];
    end
    // idle-high reset: no false falling edge on release (R8)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[g] <= 1'b1;
      else if (!frz_i) stg_q[g] <= src;
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/dbg_eev_edge.sv
module dbg_eev_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_i,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  // history always tracks the synced level; while frozen it reloads the
  // held value so no stale edge appears on stop exit (R9)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i & ~frz_i;
endmodule

// File: rtl/dbg_eev_route.sv
module dbg_eev_route
  import dbg_eev_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       armed_i,
  input  logic       fall_i,
  input  logic       lvl_i,
  output logic       seq_evt_o,
  output logic       trc_req_o,
  output logic       trc_gate_o
);
  eev_mode_e mode;
  logic      evt;

  assign mode = eev_mode_e'(mode_i);
  assign evt  = fall_i & armed_i;

  always_comb begin
    seq_evt_o  = 1'b0;
    trc_req_o  = 1'b0;
    trc_gate_o = 1'b1;
    unique case (mode)
      EEV_SEQ:   seq_evt_o  = evt;
      EEV_TRACE: trc_req_o  = evt;
      EEV_GATE:  trc_gate_o = ~lvl_i;
      default:   ;
    endcase
  end
endmodule

// File: rtl/dbg_eev_cond.sv
module dbg_eev_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eev_pin_i,
  input  logic       stop_i,
  input  logic       armed_i,
  input  logic [1:0] mode_i,
  output logic       seq_evt_o,
  output logic       trc_req_o,
  output logic       trc_gate_o
);
  logic sync_lvl;
  logic fall;

  dbg_eev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frz_i  (stop_i),
    .d_i    (eev_pin_i),
    .q_o    (sync_lvl)
  );

  dbg_eev_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frz_i  (stop_i),
    .lvl_i  (sync_lvl),
    .fall_o (fall)
  );

  dbg_eev_route u_route (
    .mode_i     (mode_i),
    .armed_i    (armed_i),
    .fall_i     (fall),
    .lvl_i      (sync_lvl),
    .seq_evt_o  (seq_evt_o),
    .trc_req_o  (trc_req_o),
    .trc_gate_o (trc_gate_o)
  );
endmodule

// File: rtl/dbg_eev_checker.sv
module dbg_eev_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eev_pin_i,
  input logic       stop_i,
  input logic       armed_i,
  input logic [1:0] mode_i,
  input logic       seq_evt_o,
  input logic       trc_req_o,
  input logic       trc_gate_o
);
  assert_seq_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_evt_o |-> (mode_i == 2'b01));
  assert_trc_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_req_o |-> (mode_i == 2'b10));
  assert_unarmed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !(seq_evt_o || trc_req_o));
  assert_stop_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !(seq_evt_o || trc_req_o));
  assert_stop_gate_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && $past(stop_i) && $past(rst_ni) && $stable(mode_i)) |-> $stable(trc_gate_o));
  assert_gate_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b11) |-> trc_gate_o);
  assert_seq_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_evt_o |=> !seq_evt_o);
  assert_trc_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_req_o |=> !trc_req_o);
endmodule

bind dbg_eev_cond dbg_eev_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eev_pin_i  (eev_pin_i),
  .stop_i     (stop_i),
  .armed_i    (armed_i),
  .mode_i     (mode_i),
  .seq_evt_o  (seq_evt_o),
  .trc_req_o  (trc_req_o),
  .trc_gate_o (trc_gate_o)
);

// File: tb/dbg_eev_cond_test.sv
module dbg_eev_cond_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       stop = 1'b0;
  logic       armed = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       seq_evt, trc_req, trc_gate;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  always #2 clk = ~clk;  // 250 MHz

  dbg_eev_cond uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .eev_pin_i  (pin),
    .stop_i     (stop),
    .armed_i    (armed),
    .mode_i     (mode),
    .seq_evt_o  (seq_evt),
    .trc_req_o  (trc_req),
    .trc_gate_o (trc_gate)
  );

  // behavioural model: queue of non-frozen pin samples, newest at front
  bit hist[$];
  bit prev_m;
  bit lvl_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1};
      prev_m = 1'b1;
      lvl_m = 1'b1;
    end else begin
      prev_m = lvl_m;
      if (!stop) begin
        hist.push_front(pin);
        void'(hist.pop_back());
      end
      lvl_m = hist[1];
    end
  end

  task automatic compare(string tag, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit fall_e;
      fall_e = prev_m && !lvl_m && !stop && armed;
      compare("seq_evt_o",  seq_evt,  fall_e && mode == 2'b01);
      compare("trc_req_o",  trc_req,  fall_e && mode == 2'b10);
      compare("trc_gate_o", trc_gate, (mode == 2'b11) ? !lvl_m : 1'b1);
    end
  end

  task automatic drive(bit p, bit s, bit a, bit [1:0] m);
    @(posedge clk);
    #1;
    pin = p; stop = s; armed = a; mode = m;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R8: reset state, gating mode reads suppress until a low is sampled
    mode = 2'b11;
    armed = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) drive(1, 0, 1, 2'b11);
    // R1 / R10: single fall in sequencer mode, 2-cycle latency
    cur_req = "R1";
    repeat (3) drive(1, 0, 1, 2'b01);
    repeat (6) drive(0, 0, 1, 2'b01);
    // R2: rising edge gives nothing
    cur_req = "R2";
    repeat (6) drive(1, 0, 1, 2'b01);
    // R3: trace-entry mode and off mode
    cur_req = "R3";
    drive(0, 0, 1, 2'b10); repeat (4) drive(0, 0, 1, 2'b10);
    repeat (3) drive(1, 0, 1, 2'b00);
    repeat (4) drive(0, 0, 1, 2'b00);
    repeat (3) drive(1, 0, 1, 2'b00);
    // R6: half-rate toggling
    cur_req = "R6";
    for (int i = 0; i < 12; i++) drive(i[0] ? 1'b0 : 1'b1, 0, 1, 2'b01);
    repeat (4) drive(1, 0, 1, 2'b01);
    // R5: unarmed ignored, then arm after pin edge before synced edge
    cur_req = "R5";
    repeat (5) drive(0, 0, 0, 2'b10);
    repeat (3) drive(1, 0, 0, 2'b10);
    drive(0, 0, 0, 2'b10);
    drive(0, 0, 1, 2'b10);
    repeat (4) drive(0, 0, 1, 2'b10);
    // R4: gating by level
    cur_req = "R4";
    repeat (4) drive(0, 0, 0, 2'b11);
    repeat (4) drive(1, 0, 0, 2'b11);
    repeat (3) drive(0, 0, 0, 2'b11);
    // R7: stop freezes; pin toggles ignored, gate holds
    cur_req = "R7";
    for (int i = 0; i < 8; i++) drive(i[0], 1, 1, 2'b11);
    for (int i = 0; i < 8; i++) drive(i[0], 1, 1, 2'b01);
    // R9: leave stop with pin at frozen level: no pulse
    cur_req = "R9";
    repeat (6) drive(0, 0, 1, 2'b01);
    repeat (3) drive(1, 0, 1, 2'b01);
    drive(1, 1, 1, 2'b01);
    repeat (3) drive(1, 1, 1, 2'b01);
    repeat (6) drive(1, 0, 1, 2'b01);
    // mixed random traffic
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive((r % 3) != 0, (r > 90), (r > 8), 2'($urandom_range(0, 3)));
    end
    @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule